// File: doc/BRIEF.md
# Dual-Bank Flash Command Sequence Decoder

This block sits on the host side of a dual-bank parallel NOR flash. It watches bus write cycles and follows the multi-cycle unlock and command sequences written to the flash. From those sequences it decides, for each read, whether the read returns array data, identification codes or sector-group protection status. The block starts in read mode, so array reads need no command first. Autoselect applies to one bank at a time. The bank named in the command returns identification data, and the other bank keeps returning array data.

The block also screens the single-cycle suspend and resume commands. It passes them on as one-cycle request pulses only while the embedded program or erase engine reports that it is busy. A reset command produces a one-cycle pulse that clears the exceeded-timing condition elsewhere. Reads are registered: a read strobe in cycle t gives `rdValid` and `rdData` after the next clock edge. The bus can run in x16 or x8 mode. In x8 mode, `byteLsb` is the byte-select address bit.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset `rdValid`, `suspReq`, `resmReq` and `tmoClr` are 0 and no bank is in autoselect. A read of either bank returns `arrayData`. A read issued in cycle t appears on `rdValid`/`rdData` one clock later.
- R2: Three writes select autoselect for the bank in `busAddr[ADDR_W-1]`: data AAh at word address low bits 555h, then data 55h at 2AAh, then 90h at any address of that bank. In x8 mode the first write must also have `byteLsb`=0 and the second `byteLsb`=1.
- R3: Only `busWrData[7:0]` is decoded. Bits 15..8 of a command write have no effect.
- R4: A write that is not the expected next cycle of a sequence takes every bank out of autoselect and restarts the sequence. This covers a wrong address, wrong data or out-of-order data, and also suspend or resume with no operation busy.
- R5: A cycle with both `busWe` and `busRe` high is taken as a write only. The read is dropped, and `rdValid` is 0 after that edge.
- R6: In autoselect, a read of the selected bank at offset 00h returns `MFR_ID` (0004h by default).
- R7: In autoselect, the device code `DEV_ID` (225Ch by default) is read at word offset 01h in x16 mode and at byte offset 02h in x8 mode. The offset is `busAddr[7:0]` in x16 mode and `{busAddr[6:0],byteLsb}` in x8 mode.
- R8: In autoselect, the protection offset (02h in x16 mode, 04h in x8 mode) returns `sgProt` on bit 0 with all other bits 0. Every other offset returns 0.
- R9: While one bank is in autoselect, reads of the other bank return `arrayData`.
- R10: When no sequence is in progress, a write of B0h pulses `suspReq` and a write of 30h pulses `resmReq` for one cycle after the write. This happens only if `pgmBusy` or `ersBusy` is high in the write cycle.
- R11: Data F0h written in any sequence state is a reset command: a lone F0h, or F0h as the third cycle after the two unlock cycles. It pulses `tmoClr` for one cycle, clears autoselect in all banks and restarts the sequence.
- R12: In x8 mode bits 15..8 of `rdData` are 0 for every read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Write cycle strobe |
| busRe | input | 1 | Read cycle strobe |
| busAddr | input | ADDR_W | Word address; top bit selects the bank |
| byteLsb | input | 1 | Byte select bit, used in x8 mode |
| busWrData | input | 16 | Write data; low byte is the command |
| byteMode | input | 1 | 1 = x8 bus, 0 = x16 bus |
| arrayData | input | 16 | Array contents at `busAddr` |
| sgProt | input | 1 | Protection flag of the sector group at `busAddr` |
| pgmBusy | input | 1 | Program operation in progress |
| ersBusy | input | 1 | Sector erase operation in progress |
| rdValid | output | 1 | Read result valid |
| rdData | output | 16 | Read result |
| suspReq | output | 1 | Suspend request pulse |
| resmReq | output | 1 | Resume request pulse |
| tmoClr | output | 1 | Reset command pulse (clears exceeded-timing state) |

## Verification
Directed sequences first enter autoselect correctly in both bus modes and both banks. They then read every identification offset and the neighbouring offsets, which separates manufacturer, device and protection decoding from array pass-through on the other bank. Further directed cases put garbage in the high data byte, use a wrong unlock address, overlap a write with a read, and issue suspend, resume and reset both with and without a busy operation. These show which writes count as valid and which drop the block to read mode. Random traffic then mixes correct entries, partial sequences and reads near offset 0 against a bench model, so that sequence restarts caused by stray writes in every state are compared cycle by cycle.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int NUM_BANKS = 2;

  localparam logic [7:0] CMD_UNL1    = 8'hAA;
  localparam logic [7:0] CMD_UNL2    = 8'h55;
  localparam logic [7:0] CMD_AUTOSEL = 8'h90;
  localparam logic [7:0] CMD_RESET   = 8'hF0;
  localparam logic [7:0] CMD_SUSP    = 8'hB0;
  localparam logic [7:0] CMD_RESUME  = 8'h30;

  localparam logic [10:0] ADR_UNL1 = 11'h555;
  localparam logic [10:0] ADR_UNL2 = 11'h2AA;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_UNL1 = 2'd1,
    SEQ_UNL2 = 2'd2
  } seqState_t;

  // strobes from control to the read datapath
  typedef struct packed {
    logic [NUM_BANKS-1:0] asMask;
    logic                 rdGo;
  } ctrlStrb_t;
endpackage

// File: rtl/fcd_ctrl.sv
module fcd_ctrl
  import fcd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWe,
  input  logic        busRe,
  input  logic [10:0] addrLow,
  input  logic        bankSel,
  input  logic        byteLsb,
  input  logic        byteMode,
  input  logic [7:0]  cmdData,
  input  logic        pgmBusy,
  input  logic        ersBusy,
  output ctrlStrb_t   strb,
  output logic        suspReq,
  output logic        resmReq,
  output logic        tmoClr
);
  seqState_t seqQ, seqD;
  logic [NUM_BANKS-1:0] asQ, asD;
  logic hit1, hit2, opBusy;
  logic suspD, resmD, tmoD;

  assign hit1   = (addrLow == ADR_UNL1) && (!byteMode || !byteLsb);
  assign hit2   = (addrLow == ADR_UNL2) && (!byteMode ||  byteLsb);
  assign opBusy = pgmBusy || ersBusy;

  always_comb begin
    seqD  = seqQ;
    asD   = asQ;
    suspD = 1'b0;
    resmD = 1'b0;
    tmoD  = 1'b0;
    if (busWe) begin
      seqD = SEQ_IDLE;
      if (cmdData == CMD_RESET) begin
        asD  = '0;
        tmoD = 1'b1;
      end else begin
        unique case (seqQ)
          SEQ_IDLE: begin
            if (cmdData == CMD_UNL1 && hit1) seqD = SEQ_UNL1;
            else if (cmdData == CMD_SUSP && opBusy) suspD = 1'b1;
            else if (cmdData == CMD_RESUME && opBusy) resmD = 1'b1;
            else asD = '0;
          end
          SEQ_UNL1: begin
            if (cmdData == CMD_UNL2 && hit2) seqD = SEQ_UNL2;
            else asD = '0;
          end
          SEQ_UNL2: begin
            if (cmdData == CMD_AUTOSEL) asD[bankSel] = 1'b1;
            else asD = '0;
          end
          default: asD = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqQ    <= SEQ_IDLE;
      suspReq <= 1'b0;
      resmReq <= 1'b0;
      tmoClr  <= 1'b0;
    end else begin
      seqQ    <= seqD;
      suspReq <= suspD;
      resmReq <= resmD;
      tmoClr  <= tmoD;
    end
  end

  for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN) asQ[gb] <= 1'b0;
      else       asQ[gb] <= asD[gb];
    end
  end

  assign strb.asMask = asQ;
  assign strb.rdGo   = busRe && !busWe;

  a_r10_susp_needs_busy: assert property (@(posedge clk) disable iff (!rstN)
    (suspReq || resmReq) |-> $past(pgmBusy || ersBusy));
  a_r2_unlock_order: assert property (@(posedge clk) disable iff (!rstN)
    (seqQ == SEQ_UNL2) |-> $past(seqQ == SEQ_UNL1));
  a_r11_reset_clears: assert property (@(posedge clk) disable iff (!rstN)
    tmoClr |-> (asQ == '0) && (seqQ == SEQ_IDLE));
endmodule

// File: rtl/fcd_rdpath.sv
module fcd_rdpath
  import fcd_pkg::*;
#(
  parameter logic [15:0] MFR_ID = 16'h0004,
  parameter logic [15:0] DEV_ID = 16'h225C
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrb_t   strb,
  input  logic [7:0]  addrOff,
  input  logic        bankSel,
  input  logic        byteLsb,
  input  logic        byteMode,
  input  logic [15:0] arrayData,
  input  logic        sgProt,
  output logic        rdValid,
  output logic [15:0] rdData
);
  localparam logic [7:0] DEV_OFF_X16  = 8'h01;
  localparam logic [7:0] DEV_OFF_X8   = 8'h02;
  localparam logic [7:0] PROT_OFF_X16 = 8'h02;
  localparam logic [7:0] PROT_OFF_X8  = 8'h04;

  logic [7:0]  off, devOff, protOff;
  logic [15:0] rdNext;

  assign off     = byteMode ? {addrOff[6:0], byteLsb} : addrOff;
  assign devOff  = byteMode ? DEV_OFF_X8  : DEV_OFF_X16;
  assign protOff = byteMode ? PROT_OFF_X8 : PROT_OFF_X16;

  always_comb begin
    if (!strb.asMask[bankSel])  rdNext = arrayData;
    else if (off == 8'h00)      rdNext = MFR_ID;
    else if (off == devOff)     rdNext = DEV_ID;
    else if (off == protOff)    rdNext = {15'b0, sgProt};
    else                        rdNext = '0;
    if (byteMode) rdNext[15:8] = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strb.rdGo;
      if (strb.rdGo) rdData <= rdNext;
    end
  end

  a_r12_x8_high_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && $past(byteMode)) |-> (rdData[15:8] == 8'h00));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int          ADDR_W = 21,
  parameter logic [15:0] MFR_ID = 16'h0004,
  parameter logic [15:0] DEV_ID = 16'h225C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              byteLsb,
  input  logic [15:0]       busWrData,
  input  logic              byteMode,
  input  logic [15:0]       arrayData,
  input  logic              sgProt,
  input  logic              pgmBusy,
  input  logic              ersBusy,
  output logic              rdValid,
  output logic [15:0]       rdData,
  output logic              suspReq,
  output logic              resmReq,
  output logic              tmoClr
);
  localparam int BANK_BIT = ADDR_W - 1;

  ctrlStrb_t strb;
  logic      bankSel;
  logic      hiByteUnused;
  logic      midAddrUnused;

  assign bankSel       = busAddr[BANK_BIT];
  assign hiByteUnused  = ^busWrData[15:8];
  assign midAddrUnused = ^busAddr[BANK_BIT-1:11];

  fcd_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busWe    (busWe),
    .busRe    (busRe),
    .addrLow  (busAddr[10:0]),
    .bankSel  (bankSel),
    .byteLsb  (byteLsb),
    .byteMode (byteMode),
    .cmdData  (busWrData[7:0]),
    .pgmBusy  (pgmBusy),
    .ersBusy  (ersBusy),
    .strb     (strb),
    .suspReq  (suspReq),
    .resmReq  (resmReq),
    .tmoClr   (tmoClr)
  );

  fcd_rdpath #(.MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_rdpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .addrOff   (busAddr[7:0]),
    .bankSel   (bankSel),
    .byteLsb   (byteLsb),
    .byteMode  (byteMode),
    .arrayData (arrayData),
    .sgProt    (sgProt),
    .rdValid   (rdValid),
    .rdData    (rdData)
  );

  a_r5_write_wins: assert property (@(posedge clk) disable iff (!rstN)
    $past(busWe) |-> !rdValid);
endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
  localparam int AW = 21;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busWe = 1'b0, busRe = 1'b0, byteLsb = 1'b0, byteMode = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [15:0]   busWrData = '0;
  logic [15:0]   arrayData;
  logic          sgProt = 1'b0, pgmBusy = 1'b0, ersBusy = 1'b0;
  logic          rdValid, suspReq, resmReq, tmoClr;
  logic [15:0]   rdData;

  int nChk = 0, nFail = 0;
  int mSeq = 0;
  bit [1:0] mAs = 2'b00;

  always #4 clk = ~clk;

  function automatic logic [15:0] arrFn(logic [AW-1:0] a);
    return a[15:0] ^ {a[20:13], 8'h5A};
  endfunction
  assign arrayData = arrFn(busAddr);

  flash_cmd_decoder u_dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .byteLsb(byteLsb), .busWrData(busWrData), .byteMode(byteMode),
    .arrayData(arrayData), .sgProt(sgProt), .pgmBusy(pgmBusy), .ersBusy(ersBusy),
    .rdValid(rdValid), .rdData(rdData), .suspReq(suspReq), .resmReq(resmReq),
    .tmoClr(tmoClr)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk(bit bank, logic [10:0] low);
    logic [8:0] hi = 9'($urandom);
    return {bank, hi, low};
  endfunction

  // model of the read result and its requirement tag
  function automatic logic [15:0] expRead(logic [AW-1:0] a, bit lsb, bit bm, bit sg,
                                          output string tag);
    logic [7:0]  off = bm ? {a[6:0], lsb} : a[7:0];
    logic [15:0] v;
    if (!mAs[a[AW-1]]) begin
      v = arrFn(a);
      tag = (mAs != 0) ? "R9 other bank" : "R1 array read";
    end else if (off == 8'h00) begin
      v = 16'h0004; tag = "R6 manufacturer";
    end else if (off == (bm ? 8'h02 : 8'h01)) begin
      v = 16'h225C; tag = "R7 device code";
    end else if (off == (bm ? 8'h04 : 8'h02)) begin
      v = {15'b0, sg}; tag = "R8 protection";
    end else begin
      v = 16'h0000; tag = "R8 other offset";
    end
    if (bm) begin
      v[15:8] = 8'h00;
      tag = {tag, " R12"};
    end
    return v;
  endfunction

  task automatic step(bit we, bit re, logic [AW-1:0] a, bit lsb, logic [15:0] d);
    logic [15:0] eData;
    string rTag;
    bit eS = 0, eR = 0, eT = 0;
    bit [7:0] c = d[7:0];
    bit busy;
    busWe = we; busRe = re; busAddr = a; byteLsb = lsb; busWrData = d;
    sgProt = 1'($urandom);
    busy = pgmBusy || ersBusy;
    eData = expRead(a, lsb, byteMode, sgProt, rTag);
    if (we) begin
      int nSeq = 0;
      if (c == 8'hF0) begin
        mAs = 0; eT = 1;
      end else if (mSeq == 0) begin
        if (c == 8'hAA && a[10:0] == 11'h555 && (!byteMode || !lsb)) nSeq = 1;
        else if (c == 8'hB0 && busy) eS = 1;
        else if (c == 8'h30 && busy) eR = 1;
        else mAs = 0;
      end else if (mSeq == 1) begin
        if (c == 8'h55 && a[10:0] == 11'h2AA && (!byteMode || lsb)) nSeq = 2;
        else mAs = 0;
      end else begin
        if (c == 8'h90) mAs[a[AW-1]] = 1'b1;
        else mAs = 0;
      end
      mSeq = nSeq;
    end
    @(posedge clk);
    @(negedge clk);
    chk(we && re ? "R5 write wins" : "R1 read valid", 16'(rdValid), 16'(re && !we));
    if (re && !we) chk(rTag, rdData, eData);
    chk("R10 suspend pulse", 16'(suspReq), 16'(eS));
    chk("R10 resume pulse", 16'(resmReq), 16'(eR));
    chk("R11 reset pulse", 16'(tmoClr), 16'(eT));
    busWe = 0; busRe = 0;
  endtask

  task automatic wr(logic [AW-1:0] a, bit lsb, logic [15:0] d);
    step(1, 0, a, lsb, d);
  endtask
  task automatic rd(logic [AW-1:0] a, bit lsb);
    step(0, 1, a, lsb, 16'h0);
  endtask
  task automatic enter(bit bank, logic [15:0] hiJunk);
    wr(mk(0, 11'h555), 1'b0, {hiJunk[15:8], 8'hAA});
    wr(mk(1, 11'h2AA), 1'b1, {hiJunk[7:0], 8'h55});
    wr(mk(bank, 11'($urandom)), 1'($urandom), 16'h0090);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++; nChk++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    chk("R1 reset rdValid", 16'(rdValid), 16'h0);
    chk("R1 reset pulses", {13'b0, suspReq, resmReq, tmoClr}, 16'h0);
    rd(mk(0, 11'h000), 0);
    rd(mk(1, 11'h001), 0);
    // R2, R6..R9 in x16
    enter(0, 16'h0000);
    for (int o = 0; o < 5; o++) rd(mk(0, 11'(o)), 0);
    rd(mk(1, 11'h001), 0);
    // R3: junk in the high data byte
    wr(mk(0, 11'h7), 0, 16'h0000);
    enter(1, 16'hA5C3);
    rd(mk(1, 11'h001), 0);
    rd(mk(0, 11'h001), 0);
    // R5: overlapping write and read
    step(1, 1, mk(1, 11'h000), 0, 16'h0012);
    rd(mk(1, 11'h000), 0);
    // R4: wrong unlock address, then suspend without busy
    enter(0, 16'h0);
    wr(mk(0, 11'h555), 0, 16'h00AA);
    wr(mk(0, 11'h2AB), 0, 16'h0055);
    wr(mk(0, 11'h000), 0, 16'h0090);
    rd(mk(0, 11'h000), 0);
    enter(0, 16'h0);
    wr(mk(0, 11'h0), 0, 16'h00B0);
    rd(mk(0, 11'h000), 0);
    // R10: with busy
    pgmBusy = 1; wr(mk(0, 11'h0), 0, 16'h00B0);
    pgmBusy = 0; ersBusy = 1; wr(mk(1, 11'h0), 0, 16'h0030);
    ersBusy = 0;
    // R11: both reset forms
    enter(1, 16'h0); wr(mk(1, 11'h0), 0, 16'h00F0); rd(mk(1, 11'h0), 0);
    enter(1, 16'h0);
    wr(mk(0, 11'h555), 0, 16'h00AA); wr(mk(0, 11'h2AA), 0, 16'h0055);
    wr(mk(0, 11'h0), 0, 16'h00F0); rd(mk(1, 11'h0), 0);
    // x8 mode: R7, R8, R12
    byteMode = 1;
    enter(1, 16'h0);
    for (int o = 0; o < 6; o++) rd(mk(1, 11'(o >> 1)), 1'(o));
    rd(mk(0, 11'h3), 1);
    wr(mk(0, 11'h555), 1, 16'h00AA);
    rd(mk(1, 11'h0), 0);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int op = $urandom_range(0, 9);
      byteMode = (i >= 2000);
      pgmBusy = ($urandom_range(0, 2) == 0);
      ersBusy = ($urandom_range(0, 3) == 0);
      case (op)
        0: enter(1'($urandom), 16'($urandom));
        1, 2: begin
          logic [7:0] cs [6] = '{8'hAA, 8'h55, 8'h90, 8'hF0, 8'hB0, 8'h30};
          logic [10:0] as [3] = '{11'h555, 11'h2AA, 11'h0};
          logic [7:0] c = ($urandom_range(0, 6) == 6) ? 8'($urandom) : cs[$urandom_range(0, 5)];
          wr(mk(1'($urandom), as[$urandom_range(0, 2)]), 1'($urandom), {8'($urandom), c});
        end
        3: step(1, 1, mk(1'($urandom), 11'($urandom)), 1'($urandom), 16'($urandom));
        default: rd(mk(1'($urandom), 11'($urandom_range(0, 4))), 1'($urandom));
      endcase
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule